// File: doc/BRIEF.md
# Infrared Link Interrupt Status, Mask and Clear Unit

This unit gathers single-cycle event pulses from an infrared link engine into sticky status bits. It filters them through two levels of masking and drives one interrupt line. Two banks hold the state. The slow bank serves the asynchronous low-rate mode. The fast bank serves the medium-rate and high-rate synchronous modes. A mode register chooses which bank collects new events. The same register also holds three top-level mask bits.

A 16-bit register bus gives software access. Reads are combinational from the current address and have no side effects. Writes take effect at the clock edge. Software reads a status register, writes the bits it has handled to the matching clear register, and sets or clears mask bits to pick which events may raise the line. Status bits 9 and 8 mean different things in each bank. In the slow bank they are receive timeout and framing error. In the fast bank they are abort detected and CRC error.

Top module: `irx_irq_unit`

## Requirements
- R1: Register word addresses are: 0 mode, 1 slow status, 2 slow mask, 3 slow clear, 4 fast status, 5 fast mask, 6 fast clear. After reset, the mode register reads 16'h0111, both mask registers read 16'h8B80, and both status registers read 0.
- R2: The mode field is bits 15:14 of the mode register. The five event inputs map to status bits as follows: link_evt[4] to bit 15 (frame received), link_evt[3] to bit 11 (buffer overflow), link_evt[2] to bit 9, link_evt[1] to bit 8, and link_evt[0] to bit 7 (frame sent). Events go to the slow bank when the mode is 00, to the fast bank when the mode is 10 or 11, and to neither bank when the mode is 01. A mode write applies to events from the next cycle on.
- R3: A status bit stays set until software writes 1 to the same bit position in that bank's clear register. Writing 0 leaves the bit unchanged.
- R4: If an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R5: A 1 in a bank mask bit keeps that status bit from raising irq. The status bit is still recorded and still reads back.
- R6: Mode register bit 0 masks the whole slow bank and bit 4 masks the whole fast bank, where 1 means masked. Bit 8 is stored and reads back but has no effect on irq.
- R7: irq is high exactly when some slow status bit is set and unmasked while mode bit 0 is 0, or some fast status bit is set and unmasked while mode bit 4 is 0. This holds whatever the current mode.
- R8: Only bits 15, 11, 9, 8 and 7 exist in the status, mask and clear registers. Only bits 15:14, 8, 4 and 0 exist in the mode register. Other bits ignore writes and read 0. Writes to a status register are ignored. Clear registers and address 7 read 0.
- R9: Reading any address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_evt | input | 5 | Single-cycle event pulses from the link engine |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
An event pulse and a software clear can land on the same status bit in the same clock. The bench provokes this in directed cases: it writes the slow clear register with the bit set while the matching event is pulsed. It also does this for the fast bank and in random cycles that mix clear writes with events. In every such cycle the bit is expected to read back set afterwards, and irq must follow the bench model. A mode write in the same cycle as an event is judged the same way: the event must land in the bank chosen by the old mode.

// File: rtl/irx_irq_unit.sv
module irx_irq_unit #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        link_evt,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SST  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SMSK = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_SCLR = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_FST  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_FMSK = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_FCLR = ADDR_W'(6);
  localparam logic [15:0] BANK_BITS = 16'h8B80;

  logic [1:0]  mode;
  logic [2:0]  top_m;
  logic [15:0] slow_st, fast_st, slow_msk, fast_msk;

  wire [15:0] evt_w = {link_evt[4], 3'b000, link_evt[3], 1'b0,
                       link_evt[2], link_evt[1], link_evt[0], 7'b0};
  wire slow_sel = (mode == 2'b00);
  wire fast_sel = mode[1];
  wire [15:0] wbits = bus_wdata & BANK_BITS;
  wire [15:0] slow_clr = (bus_we && bus_addr == A_SCLR) ? wbits : 16'h0;
  wire [15:0] fast_clr = (bus_we && bus_addr == A_FCLR) ? wbits : 16'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= 2'b00;
      top_m    <= 3'b111;
      slow_st  <= 16'h0;
      fast_st  <= 16'h0;
      slow_msk <= BANK_BITS;
      fast_msk <= BANK_BITS;
    end else begin
      slow_st <= (slow_st & ~slow_clr) | (slow_sel ? evt_w : 16'h0);
      fast_st <= (fast_st & ~fast_clr) | (fast_sel ? evt_w : 16'h0);
      if (bus_we) begin
        if (bus_addr == A_MODE) begin
          mode  <= bus_wdata[15:14];
          top_m <= {bus_wdata[8], bus_wdata[4], bus_wdata[0]};
        end
        if (bus_addr == A_SMSK) slow_msk <= wbits;
        if (bus_addr == A_FMSK) fast_msk <= wbits;
      end
    end
  end

  assign irq = ((|(slow_st & ~slow_msk)) & ~top_m[0]) |
               ((|(fast_st & ~fast_msk)) & ~top_m[1]);

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = {mode, 5'b0, top_m[2], 3'b0, top_m[1], 3'b0, top_m[0]};
      A_SST:   bus_rdata = slow_st;
      A_SMSK:  bus_rdata = slow_msk;
      A_FST:   bus_rdata = fast_st;
      A_FMSK:  bus_rdata = fast_msk;
      default: bus_rdata = 16'h0;
    endcase
  end
endmodule

// File: rtl/irx_irq_unit_chk.sv
module irx_irq_unit_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        link_evt,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [15:0]       bus_wdata,
  input logic [15:0]       bus_rdata,
  input logic              irq,
  input logic [1:0]        mode,
  input logic [15:0]       sst,
  input logic [15:0]       fst,
  input logic [15:0]       smsk,
  input logic [15:0]       fmsk
);
  localparam logic [ADDR_W-1:0] A_SCLR = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_FCLR = ADDR_W'(6);
  localparam logic [15:0] BANK_BITS = 16'h8B80;

  assert_sticky_slow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == A_SCLR) |=> ((sst & $past(sst)) == $past(sst)));

  assert_sticky_fast_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == A_FCLR) |=> ((fst & $past(fst)) == $past(fst)));

  assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_SCLR && bus_wdata[15] && mode == 2'b00 && link_evt[4])
      |=> sst[15]);

  assert_reserved_mode_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && !bus_we) |=> (sst == $past(sst) && fst == $past(fst)));

  assert_irq_needs_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((sst | fst) != 16'h0));

  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((sst & ~smsk) == 16'h0 && (fst & ~fmsk) == 16'h0) |-> !irq);

  assert_no_phantom_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((sst | fst) & ~BANK_BITS) == 16'h0);
endmodule

bind irx_irq_unit irx_irq_unit_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .link_evt(link_evt), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .irq(irq), .mode(mode), .sst(slow_st), .fst(fast_st),
  .smsk(slow_msk), .fmsk(fast_msk)
);

// File: tb/irx_irq_unit_tb.sv
module irx_irq_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  link_evt = 5'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_mode, m_sst, m_fst, m_smsk, m_fmsk;

  always #2 clk = ~clk;

  irx_irq_unit #(.ADDR_W(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .link_evt(link_evt), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [15:0] spread(input logic [4:0] e);
    return {e[4], 3'b0, e[3], 1'b0, e[2], e[1], e[0], 7'b0};
  endfunction

  function automatic logic exp_irq();
    return (((m_sst & ~m_smsk) != 0) && !m_mode[0]) ||
           (((m_fst & ~m_fmsk) != 0) && !m_mode[4]);
  endfunction

  function automatic logic [15:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_mode;
      3'd1: return m_sst;
      3'd2: return m_smsk;
      3'd4: return m_fst;
      3'd5: return m_fmsk;
      default: return 16'h0;
    endcase
  endfunction

  task automatic model_reset();
    m_mode = 16'h0111; m_sst = 0; m_fst = 0; m_smsk = 16'h8B80; m_fmsk = 16'h8B80;
  endtask

  task automatic model_step(input logic [4:0] e, input logic we, input logic [2:0] a,
                            input logic [15:0] d);
    logic [15:0] ev = spread(e);
    logic [15:0] db = d & 16'h8B80;
    logic [1:0]  md = m_mode[15:14];
    if (we && a == 3'd3) m_sst = m_sst & ~db;
    if (we && a == 3'd6) m_fst = m_fst & ~db;
    if (md == 2'b00) m_sst = m_sst | ev;
    if (md[1])       m_fst = m_fst | ev;
    if (we && a == 3'd0) m_mode = d & 16'hC111;
    if (we && a == 3'd2) m_smsk = db;
    if (we && a == 3'd5) m_fmsk = db;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [4:0] e, input logic we, input logic [2:0] a,
                     input logic [15:0] d);
    @(negedge clk);
    link_evt = e; bus_we = we; bus_addr = a; bus_wdata = d;
    model_step(e, we, a, d);
    @(posedge clk);
    #1;
    link_evt = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, input string req);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp_rd(a));
  endtask

  task automatic irq_chk(input string req);
    @(negedge clk);
    check(req, {15'b0, irq}, {15'b0, exp_irq()});
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    for (int a = 0; a < 8; a++) rd(3'(a), "R1 reset state");
    irq_chk("R1 reset irq low");

    // R5/R6: events recorded while everything is masked
    cyc(5'b10000, 0, 0, 0);
    rd(3'd1, "R5 slow status recorded under mask");
    irq_chk("R5 masked irq low");
    cyc(0, 1, 3'd2, 16'h0000);
    irq_chk("R6 top slow mask blocks irq");
    cyc(0, 1, 3'd0, 16'h0010);
    irq_chk("R6 slow bank unmasked raises irq");
    cyc(0, 1, 3'd0, 16'h0101);
    irq_chk("R6 fifo mask bit no irq effect");
    rd(3'd0, "R6 fifo mask bit readback");

    // R4 collision in slow bank
    cyc(5'b10000, 1, 3'd3, 16'h8000);
    rd(3'd1, "R4 event beats clear slow");
    cyc(0, 1, 3'd3, 16'hFFFF);
    rd(3'd1, "R3 clear by write one");
    irq_chk("R3 irq drops after clear");

    // R8 writes ignored / undefined bits
    cyc(0, 1, 3'd1, 16'hFFFF);
    rd(3'd1, "R8 status write ignored");
    cyc(0, 1, 3'd2, 16'hFFFF);
    rd(3'd2, "R8 mask undefined bits zero");
    rd(3'd3, "R8 clear reads zero");
    rd(3'd7, "R8 unused address zero");

    // R2 routing: reserved mode and fast modes, event with mode write
    cyc(0, 1, 3'd0, 16'h4000);
    cyc(5'b11111, 0, 0, 0);
    rd(3'd1, "R2 reserved mode drops slow");
    rd(3'd4, "R2 reserved mode drops fast");
    cyc(5'b00110, 1, 3'd0, 16'h8000);
    rd(3'd4, "R2 event uses old mode");
    cyc(5'b01001, 0, 0, 0);
    rd(3'd4, "R2 fast mode routes to fast bank");
    cyc(0, 1, 3'd5, 16'h0000);
    irq_chk("R7 fast bank raises irq");
    cyc(5'b00010, 1, 3'd6, 16'h0100);
    rd(3'd4, "R4 event beats clear fast");
    cyc(0, 1, 3'd0, 16'hC010);
    irq_chk("R6 fast top mask blocks irq");
    cyc(0, 1, 3'd0, 16'h0000);
    irq_chk("R7 inactive fast bank still drives irq");
    rd(3'd4, "R9 read has no side effect");
    rd(3'd4, "R9 repeated read stable");

    for (int i = 0; i < 1500; i++) begin
      logic [4:0]  e = ($urandom % 3 == 0) ? 5'($urandom) : 5'b0;
      logic        we = ($urandom % 2) == 1;
      logic [2:0]  a = 3'($urandom);
      logic [15:0] d = 16'($urandom);
      if (a == 3'd0 && ($urandom % 2) == 1) d = d & 16'hFFEE;
      cyc(e, we, a, d);
      irq_chk("R7 random irq");
      rd(3'($urandom), "R3 random readback");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule